// File: doc/BRIEF.md
# Rejected Interrupt Replay Bitmap

This block keeps track of interrupts that an interrupt presenter could not accept, and later replays them on request. A rejection arrives as a global interrupt number. The block subtracts a configured base from that number to get a local source number, and records the source in a two-level bitmap. The lower level is an array of words, one bit per source. The upper level is a summary vector with one bit per word. With the default parameters the bitmap has 32 words of 64 bits, which covers 2048 sources.

When the replay trigger arrives, a scanner visits the summary bits from the lowest index upwards and skips every word whose summary bit is clear. It clears each summary bit before it walks that word. Inside the word it takes the set bits in ascending order, clears each one, and offers it downstream as a forced-send request. Each request uses a valid/ready handshake and carries the local source number. A rejection that arrives while a pass is running is never lost: if the scanner has not yet reached it, it is replayed in the same pass; otherwise it stays recorded until the next trigger.

The word count and word width must be powers of two. The source number is the word index followed by the bit index.

Top module: `rejReplay`

## Requirements
- R1: A rejection with global number g, where cfgBase <= g < cfgBase + NUM_WORDS*WORD_BITS, records local source s = g - cfgBase. Source s sits in word s / WORD_BITS at bit s % WORD_BITS, and a later trigger replays it with sendSrc = s.
- R2: A rejection below cfgBase, or at or above cfgBase + NUM_WORDS*WORD_BITS, raises rejectBad in the same cycle and records nothing. A rejection in range keeps rejectBad low.
- R3: A replay trigger sends every recorded source exactly once, in ascending source order, and clears each one. A second trigger with no new rejections sends nothing.
- R4: A trigger with nothing recorded sends nothing, and busy is low in the cycle after the trigger.
- R5: Once sendValid is high it stays high, with sendSrc unchanged, until sendReady is seen high. Each valid-and-ready cycle transfers exactly one source.
- R6: A rejection that arrives during a pass is replayed in that pass if it falls in a word the scan has not reached yet, or at a higher bit of the word now being walked.
- R7: A rejection that arrives during a pass at a bit not above the one already taken from the current word, or in a word already passed, stays recorded and is replayed by the next trigger.
- R8: Several rejections of the same source before a trigger produce a single replay.
- R9: Reset clears every recorded source and the summary, and leaves busy and sendValid low.
- R10: A trigger that arrives while busy is high has no effect on the pass in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgBase | input | IRQ_W | Global number of local source 0 |
| rejectValid | input | 1 | A rejection is presented this cycle |
| rejectIrq | input | IRQ_W | Global number of the rejected interrupt |
| rejectBad | output | 1 | The presented rejection is out of range and is dropped |
| resendReq | input | 1 | Replay trigger, sampled while idle |
| busy | output | 1 | A replay pass is running |
| sendValid | output | 1 | A forced-send request is offered |
| sendReady | input | 1 | The dispatcher accepts the request |
| sendSrc | output | log2(NUM_WORDS*WORD_BITS) | Local source number of the request |

## Verification
The assertions assume that cfgBase is held steady while rejections arrive. They also assume that the dispatcher may hold sendReady low for any length of time but never takes a request unless sendValid is high. The bench changes cfgBase only before the first rejection. It drives sendReady either held high, toggling in a fixed pattern, or held low while it injects rejections in the middle of a pass. It drives every input just after a falling edge, so each rejection and trigger lands on a single rising edge.

// File: rtl/rejReplayPkg.sv
package rejReplayPkg;
  // Upper bound on index widths carried in the strobe struct (256 words / 256 bits).
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             clrBit;   // clear wordQ[bitWord][bitIdx]
    logic             clrSum;   // clear summary[sumIdx]
    logic [IDX_W-1:0] bitWord;
    logic [IDX_W-1:0] bitIdx;
    logic [IDX_W-1:0] sumIdx;
  } scanStrobe_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_WORD  = 2'd1,
    S_ISSUE = 2'd2
  } scanState_t;
endpackage

// File: rtl/rejPriEnc.sv
// Lowest-set-bit finder.
module rejPriEnc #(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rejBitmap.sv
// Datapath: source bitmap, summary vector, and reject decode.
module rejBitmap
  import rejReplayPkg::*;
#(
  parameter int NUM_WORDS = 32,
  parameter int WORD_BITS = 64,
  parameter int IRQ_W     = 20,
  localparam int WIDX_W   = $clog2(NUM_WORDS),
  localparam int BIDX_W   = $clog2(WORD_BITS),
  localparam int SRC_W    = WIDX_W + BIDX_W,
  localparam int TOTAL    = NUM_WORDS * WORD_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IRQ_W-1:0]     cfgBase,
  input  logic                 rejectValid,
  input  logic [IRQ_W-1:0]     rejectIrq,
  output logic                 rejectBad,
  input  scanStrobe_t          stb,
  input  logic [WIDX_W-1:0]    rdWord,
  output logic [NUM_WORDS-1:0] summary,
  output logic [WORD_BITS-1:0] rdBits
);
  logic [WORD_BITS-1:0] wordQ    [NUM_WORDS];
  logic [WORD_BITS-1:0] wordNext [NUM_WORDS];
  logic [NUM_WORDS-1:0] sumQ, sumNext;

  logic [IRQ_W-1:0]  diff;
  logic              outOfRange;
  logic              setEn;
  logic [WIDX_W-1:0] setWord;
  logic [BIDX_W-1:0] setBit;
  logic [WIDX_W-1:0] clrWord;
  logic [BIDX_W-1:0] clrBitIdx;
  logic [WIDX_W-1:0] clrSumIdx;

  assign diff       = rejectIrq - cfgBase;
  assign outOfRange = (rejectIrq < cfgBase) || (diff >= IRQ_W'(TOTAL));
  assign rejectBad  = rejectValid && outOfRange;
  assign setEn      = rejectValid && !outOfRange;
  assign setWord    = diff[SRC_W-1:BIDX_W];
  assign setBit     = diff[BIDX_W-1:0];

  assign clrWord    = stb.bitWord[WIDX_W-1:0];
  assign clrBitIdx  = stb.bitIdx[BIDX_W-1:0];
  assign clrSumIdx  = stb.sumIdx[WIDX_W-1:0];

  // Clears from the scanner first, then the reject set: a same-cycle set wins.
  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) wordNext[w] = wordQ[w];
    sumNext = sumQ;
    if (stb.clrBit) wordNext[clrWord][clrBitIdx] = 1'b0;
    if (stb.clrSum) sumNext[clrSumIdx] = 1'b0;
    if (setEn) begin
      wordNext[setWord][setBit] = 1'b1;
      sumNext[setWord]          = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < NUM_WORDS; w++) wordQ[w] <= '0;
      sumQ <= '0;
    end else begin
      for (int w = 0; w < NUM_WORDS; w++) wordQ[w] <= wordNext[w];
      sumQ <= sumNext;
    end
  end

  assign summary = sumQ;
  assign rdBits  = wordQ[rdWord];

  // R1: an accepted reject is visible in both levels on the next cycle.
  p_recorded_r1: assert property (@(posedge clk) disable iff (!rstN)
    setEn |=> (sumQ[$past(setWord)] && wordQ[$past(setWord)][$past(setBit)]));

  // R3: a bit taken by the scanner is gone next cycle unless re-rejected at once.
  p_cleared_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrBit && !(setEn && setWord == clrWord && setBit == clrBitIdx))
      |=> !wordQ[$past(clrWord)][$past(clrBitIdx)]);
endmodule

// File: rtl/rejScanCtl.sv
// Control: summary-guided scan and the forced-send handshake.
module rejScanCtl
  import rejReplayPkg::*;
#(
  parameter int NUM_WORDS = 32,
  parameter int WORD_BITS = 64,
  localparam int WIDX_W   = $clog2(NUM_WORDS),
  localparam int BIDX_W   = $clog2(WORD_BITS),
  localparam int SRC_W    = WIDX_W + BIDX_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 resendReq,
  input  logic [NUM_WORDS-1:0] summary,
  input  logic [WORD_BITS-1:0] rdBits,
  input  logic                 sendReady,
  output scanStrobe_t          stb,
  output logic [WIDX_W-1:0]    rdWord,
  output logic                 busy,
  output logic                 sendValid,
  output logic [SRC_W-1:0]     sendSrc
);
  scanState_t         state;
  logic [WIDX_W-1:0]  curWord;
  logic [BIDX_W:0]    bitPtr;   // one extra bit: WORD_BITS means word exhausted
  logic [SRC_W-1:0]   srcQ;

  logic [NUM_WORDS-1:0] sumMask, sumCand;
  logic [WORD_BITS-1:0] bitMask, bitCand;
  logic                 sumFound, bitFound;
  logic [WIDX_W-1:0]    sumIdx;
  logic [BIDX_W-1:0]    bitIdx;

  // Idle: any word qualifies. Scanning: only words above the current one.
  always_comb begin
    for (int i = 0; i < NUM_WORDS; i++)
      sumMask[i] = (state == S_IDLE) || (i > int'(curWord));
    for (int j = 0; j < WORD_BITS; j++)
      bitMask[j] = (j >= int'(bitPtr));
  end

  assign sumCand = summary & sumMask;
  assign bitCand = rdBits & bitMask;

  rejPriEnc #(.W(NUM_WORDS), .IW(WIDX_W)) u_sumEnc (
    .vec(sumCand), .found(sumFound), .idx(sumIdx));

  rejPriEnc #(.W(WORD_BITS), .IW(BIDX_W)) u_bitEnc (
    .vec(bitCand), .found(bitFound), .idx(bitIdx));

  always_comb begin
    stb         = '0;
    stb.bitWord = IDX_W'(curWord);
    stb.bitIdx  = IDX_W'(bitIdx);
    stb.sumIdx  = IDX_W'(sumIdx);
    case (state)
      S_IDLE:  stb.clrSum = resendReq && sumFound;
      S_WORD: begin
        stb.clrBit = bitFound;
        stb.clrSum = !bitFound && sumFound;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      curWord <= '0;
      bitPtr  <= '0;
      srcQ    <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (resendReq && sumFound) begin
            curWord <= sumIdx;
            bitPtr  <= '0;
            state   <= S_WORD;
          end
        end
        S_WORD: begin
          if (bitFound) begin
            srcQ   <= {curWord, bitIdx};
            bitPtr <= {1'b0, bitIdx} + 1'b1;
            state  <= S_ISSUE;
          end else if (sumFound) begin
            curWord <= sumIdx;
            bitPtr  <= '0;
          end else begin
            state <= S_IDLE;
          end
        end
        S_ISSUE: begin
          if (sendReady) state <= S_WORD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rdWord    = curWord;
  assign busy      = (state != S_IDLE);
  assign sendValid = (state == S_ISSUE);
  assign sendSrc   = srcQ;

  // R5: an offered request is held steady until it is accepted.
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sendValid && !sendReady) |=> (sendValid && $stable(sendSrc)));

  // R4: a trigger with an empty summary leaves the block idle.
  p_empty_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && resendReq && summary == '0) |=> !busy);

  // R10: a trigger while busy does not restart the walk of the current word.
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && resendReq && !sendValid && bitFound) |=> (sendValid && sendSrc[BIDX_W-1:0] >= $past(bitPtr[BIDX_W-1:0])));
endmodule

// File: rtl/rejReplay.sv
// Top: reject bitmap with summary-guided forced-send replay.
module rejReplay
  import rejReplayPkg::*;
#(
  parameter int NUM_WORDS = 32,   // power of two, 2..256
  parameter int WORD_BITS = 64,   // power of two, 2..256
  parameter int IRQ_W     = 20,   // must exceed log2(NUM_WORDS*WORD_BITS)
  localparam int SRC_W    = $clog2(NUM_WORDS) + $clog2(WORD_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IRQ_W-1:0] cfgBase,
  input  logic             rejectValid,
  input  logic [IRQ_W-1:0] rejectIrq,
  output logic             rejectBad,
  input  logic             resendReq,
  output logic             busy,
  output logic             sendValid,
  input  logic             sendReady,
  output logic [SRC_W-1:0] sendSrc
);
  localparam int WIDX_W = $clog2(NUM_WORDS);

  scanStrobe_t          stb;
  logic [WIDX_W-1:0]    rdWord;
  logic [NUM_WORDS-1:0] summary;
  logic [WORD_BITS-1:0] rdBits;

  rejBitmap #(.NUM_WORDS(NUM_WORDS), .WORD_BITS(WORD_BITS), .IRQ_W(IRQ_W)) u_map (
    .clk(clk), .rstN(rstN), .cfgBase(cfgBase),
    .rejectValid(rejectValid), .rejectIrq(rejectIrq), .rejectBad(rejectBad),
    .stb(stb), .rdWord(rdWord), .summary(summary), .rdBits(rdBits));

  rejScanCtl #(.NUM_WORDS(NUM_WORDS), .WORD_BITS(WORD_BITS)) u_ctl (
    .clk(clk), .rstN(rstN), .resendReq(resendReq),
    .summary(summary), .rdBits(rdBits), .sendReady(sendReady),
    .stb(stb), .rdWord(rdWord), .busy(busy),
    .sendValid(sendValid), .sendSrc(sendSrc));

  // R9: nothing is offered while no pass runs.
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sendValid);
endmodule

// File: tb/sim_rejReplay.sv
`timescale 1ns/1ps
module sim_rejReplay;
  localparam int NW = 4, WB = 8, IW = 12, TOT = NW * WB, SW = 5;
  localparam int BASE = 100;

  logic clk = 1'b0, rstN = 1'b0;
  logic [IW-1:0] cfgBase = IW'(BASE);
  logic rejectValid = 1'b0, resendReq = 1'b0, sendReady = 1'b1;
  logic [IW-1:0] rejectIrq = '0;
  logic rejectBad, busy, sendValid;
  logic [SW-1:0] sendSrc;

  int checks = 0, fails = 0, cyc = 0;
  int expv[64]; int nExp;
  int got[64];

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  rejReplay #(.NUM_WORDS(NW), .WORD_BITS(WB), .IRQ_W(IW)) u0 (
    .clk(clk), .rstN(rstN), .cfgBase(cfgBase),
    .rejectValid(rejectValid), .rejectIrq(rejectIrq), .rejectBad(rejectBad),
    .resendReq(resendReq), .busy(busy), .sendValid(sendValid),
    .sendReady(sendReady), .sendSrc(sendSrc));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReject(input int irq, input int expBad, input string req);
    @(negedge clk);
    rejectValid = 1'b1; rejectIrq = IW'(irq);
    #1;
    if (expBad >= 0) chk(rejectBad == expBad[0], req, int'(rejectBad), expBad);
    @(negedge clk);
    rejectValid = 1'b0;
  endtask

  // Collects one pass; mode 0 ready high, mode 1 ready toggles.
  task automatic runPass(input bit doTrig, input int mode, input string req);
    int n = 0; bit holdOk = 1'b1; bit stalled = 1'b0; int lastSrc = -1; int badAt = -1;
    if (doTrig) begin
      @(negedge clk); resendReq = 1'b1;
      @(negedge clk); resendReq = 1'b0;
    end
    for (int k = 0; k < 3000; k++) begin
      sendReady = (mode == 0) ? 1'b1 : (k % 3 != 1);
      #1;
      if (stalled && !(sendValid && int'(sendSrc) == lastSrc)) holdOk = 1'b0;
      stalled = 1'b0;
      if (sendValid && sendReady) begin
        if (n < 64) got[n] = int'(sendSrc);
        n++;
      end else if (sendValid) begin
        stalled = 1'b1; lastSrc = int'(sendSrc);
      end
      if (!busy && !sendValid) break;
      @(negedge clk);
    end
    sendReady = 1'b1;
    chk(n == nExp, {req, " send count"}, n, nExp);
    for (int i = 0; i < nExp && i < n; i++)
      if (badAt < 0 && got[i] != expv[i]) badAt = i;
    chk(badAt < 0, {req, " order/content"}, (badAt < 0) ? 0 : got[badAt], (badAt < 0) ? 0 : expv[badAt]);
    if (mode != 0) chk(holdOk, "R5 hold under stall", int'(holdOk), 1);
  endtask

  initial begin
    // R9: reset state
    #35; rstN = 1'b1;
    @(negedge clk);
    chk(!busy, "R9 busy after reset", int'(busy), 0);
    chk(!sendValid, "R9 sendValid after reset", int'(sendValid), 0);

    // R4: empty trigger
    @(negedge clk); resendReq = 1'b1;
    @(negedge clk); resendReq = 1'b0; #1;
    chk(!busy, "R4 busy after empty trigger", int'(busy), 0);
    nExp = 0; runPass(1'b1, 0, "R4 empty pass");

    // R1: every single source maps and replays
    for (int s = 0; s < TOT; s++) begin
      doReject(BASE + s, 0, "R2 in-range flag low");
      nExp = 1; expv[0] = s;
      runPass(1'b1, s % 2, "R1 single source");
    end

    // R3/R8: pattern injected descending with duplicates, replayed ascending
    for (int s = TOT - 1; s >= 0; s--)
      if (s % 3 == 0) doReject(BASE + s, -1, "");
    doReject(BASE + 9, -1, ""); doReject(BASE + 9, -1, "");
    nExp = 0;
    for (int s = 0; s < TOT; s++) if (s % 3 == 0) begin expv[nExp] = s; nExp++; end
    runPass(1'b1, 1, "R3 R8 pattern ascending");
    nExp = 0; runPass(1'b1, 0, "R3 cleared after pass");

    // R3: all sources at once
    for (int s = 0; s < TOT; s++) doReject(BASE + ((s * 13) % TOT), -1, "");
    nExp = TOT; for (int s = 0; s < TOT; s++) expv[s] = s;
    runPass(1'b1, 1, "R3 full bitmap");

    // R2: out of range
    doReject(BASE - 1, 1, "R2 below base flagged");
    doReject(BASE + TOT, 1, "R2 above range flagged");
    doReject(BASE + TOT + 7, 1, "R2 far above flagged");
    doReject(BASE + TOT - 1, 0, "R2 top source accepted");
    nExp = 1; expv[0] = TOT - 1;
    runPass(1'b1, 0, "R2 only in-range recorded");

    // R6/R7/R10: rejections during a stalled pass
    doReject(BASE + 1, -1, ""); doReject(BASE + 20, -1, "");
    sendReady = 1'b0;
    @(negedge clk); resendReq = 1'b1;
    @(negedge clk); resendReq = 1'b0;
    for (int k = 0; k < 20 && !sendValid; k++) @(negedge clk);
    chk(sendValid && sendSrc == 5'd1, "R5 first offer held", int'(sendSrc), 1);
    doReject(BASE + 0, -1, "");
    doReject(BASE + 5, -1, "");
    doReject(BASE + 28, -1, "");
    @(negedge clk); resendReq = 1'b1;   // R10 trigger while busy
    @(negedge clk); resendReq = 1'b0;
    chk(sendValid && sendSrc == 5'd1, "R10 offer unchanged", int'(sendSrc), 1);
    nExp = 4; expv[0] = 1; expv[1] = 5; expv[2] = 20; expv[3] = 28;
    runPass(1'b0, 1, "R6 late rejects same pass");
    nExp = 1; expv[0] = 0;
    runPass(1'b1, 0, "R7 earlier reject next pass");

    // R9: reset drops records
    doReject(BASE + 3, -1, ""); doReject(BASE + 30, -1, "");
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    nExp = 0; runPass(1'b1, 0, "R9 reset clears records");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule